// File: doc/BRIEF.md
# Sequential Buffer Address Pointer

This block generates addresses for the streaming side of an 8192-word by 16-bit shared buffer. It holds a 13-bit pointer. On a clock edge the pointer can count up by one, take a value from the streaming data bus, or jump to one of two programmable start addresses. Two end-of-buffer comparators watch the counting path. Each one drives a sticky active-low flag that is raised when counting lands on its end address. The block also turns the streaming chip enable, read/write and output-enable controls into registered array read and write strobes, plus an output-enable qualifier for the data pads.

A direct load is a two-step operation. The low 12 bits of the bus are captured into a holding register on the edge where the load control is low, and the pointer takes that value one edge later. For this reason a start-address jump must not be requested during the load edge or during the edge that follows it. Such a request is reported on a one-cycle protocol-error output.

Start and end addresses are written through a small configuration port. A control register on the same port clears the flags.

Top module: `seq_addr_gen`

## Requirements
- R1: While synchronous active-high `rst` is high at an edge, the next outputs are: pointer 0, both flags high, both strobes low, `proto_err` low and `out_en` low. All start and end registers also return to 0.
- R2: At an edge with `cnt_en_n` low and no higher-priority source, the pointer increments by one, whatever `ce_n` is doing, and wraps from 8191 to 0. With `cnt_en_n` high and no other source active, the pointer holds.
- R3: At an edge with `ld_n` low, `sdata[11:0]` is captured. At the next edge the pointer becomes that value, zero-extended; `sdata[15:12]` plays no part. At the capture edge itself the pointer follows the other controls.
- R4: At an edge with `start1_n` low the pointer takes start register 1; with `start2_n` low it takes start register 2. If both are low, start 1 wins. A start request beats an increment.
- R5: A pending direct load (the edge after `ld_n` low) beats both start requests and the increment.
- R6: A configuration write (`cfg_we` high) at address 0, 1, 2 or 3 sets start 1, start 2, end 1 or end 2 respectively, from `cfg_wdata`. A write to any other address except 5 changes nothing.
- R7: A flag goes low after an edge at which an increment makes the pointer equal to that flag's end register. Reaching the end value by a start jump or a direct load does not change the flag.
- R8: A flag stays low until reset, or until a write to address 5 carries 0 in bit 0 (flag 1) or bit 1 (flag 2); a 1 in that bit leaves the flag unchanged. If a set and a clear hit the same flag on the same edge, the set wins.
- R9: `wr_stb` is high for the cycle after an edge with `ce_n` low and `rw_n` low. `rd_stb` is high for the cycle after an edge with `ce_n` low, `rw_n` high and `oe_n` low. Otherwise both are low.
- R10: `out_en` is high when the last edge saw `ce_n` low with `rw_n` high and the current `oe_n` is low. It follows `oe_n` without waiting for a clock.
- R11: `proto_err` is high for one cycle after an edge at which a start request is low while `ld_n` is low or while a direct load is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_n | input | 1 | Active-low count enable |
| ld_n | input | 1 | Active-low direct load from the data bus |
| start1_n | input | 1 | Active-low jump to start register 1 |
| start2_n | input | 1 | Active-low jump to start register 2 |
| ce_n | input | 1 | Active-low streaming port enable |
| rw_n | input | 1 | High read, low write |
| oe_n | input | 1 | Active-low output enable |
| sdata | input | 16 | Streaming data bus, low 12 bits used for loads |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 13 | Configuration write data |
| ptr | output | 13 | Current pointer |
| wr_stb | output | 1 | Array write strobe |
| rd_stb | output | 1 | Array read strobe |
| out_en | output | 1 | Pad output-enable qualifier |
| eob1_n | output | 1 | Active-low end-of-buffer flag 1 |
| eob2_n | output | 1 | Active-low end-of-buffer flag 2 |
| proto_err | output | 1 | One-cycle load/start rule violation |

## Verification
The pointer is run through every address by pure counting, with `ce_n` toggling. This shows that counting does not depend on the port enable, that the wrap happens exactly at 8191, and that the flag sets only on a counted arrival. Every 12-bit load value is applied with junk in the upper bus bits and the count enable held low. This separates the one-edge delay, the zero extension and load-over-count priority from an immediate or truncated load. Start jumps are tried singly, together, onto an end address, and against a pending load. All eight combinations of enable, direction and output enable are applied to the strobes, and `oe_n` is toggled between edges to show that `out_en` responds without a clock.

// File: rtl/seq_ptr_pkg.sv
package seq_ptr_pkg;
  localparam int N_BUF  = 2;
  localparam int CFG_AW = 3;

  localparam logic [CFG_AW-1:0] CFG_START_BASE = 3'd0;
  localparam logic [CFG_AW-1:0] CFG_END_BASE   = 3'd2;
  localparam logic [CFG_AW-1:0] CFG_CTRL       = 3'd5;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_INC   = 2'd1,
    SRC_START = 2'd2,
    SRC_LOAD  = 2'd3
  } ptr_src_e;
endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import seq_ptr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [CFG_AW-1:0]             addr,
  input  logic [ADDR_W-1:0]             wdata,
  output logic [N_BUF-1:0][ADDR_W-1:0]  start_val,
  output logic [N_BUF-1:0][ADDR_W-1:0]  end_val,
  output logic [N_BUF-1:0]              clr
);
  for (genvar i = 0; i < N_BUF; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst) begin
        start_val[i] <= '0;
        end_val[i]   <= '0;
      end else if (we) begin
        if (addr == CFG_START_BASE + CFG_AW'(i)) start_val[i] <= wdata;
        if (addr == CFG_END_BASE + CFG_AW'(i))   end_val[i]   <= wdata;
      end
    end
    assign clr[i] = we && (addr == CFG_CTRL) && !wdata[i];
  end
endmodule

// File: rtl/ptr_core.sv
module ptr_core
  import seq_ptr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LD_W   = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cnt_en_n,
  input  logic                          ld_n,
  input  logic                          start1_n,
  input  logic                          start2_n,
  input  logic [LD_W-1:0]               ld_data,
  input  logic [N_BUF-1:0][ADDR_W-1:0]  start_val,
  output logic [ADDR_W-1:0]             ptr_q,
  output logic                          ld_pend,
  output logic                          inc_fire,
  output logic [ADDR_W-1:0]             inc_val
);
  logic [LD_W-1:0]   din_q;
  logic [ADDR_W-1:0] start_sel;
  ptr_src_e          src;

  always_comb begin
    if (ld_pend)                     src = SRC_LOAD;
    else if (!start1_n || !start2_n) src = SRC_START;
    else if (!cnt_en_n)              src = SRC_INC;
    else                             src = SRC_HOLD;
  end

  assign start_sel = !start1_n ? start_val[0] : start_val[1];
  assign inc_val   = ptr_q + ADDR_W'(1);
  assign inc_fire  = (src == SRC_INC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      din_q   <= '0;
      ld_pend <= 1'b0;
    end else begin
      ld_pend <= !ld_n;
      if (!ld_n) din_q <= ld_data;
      case (src)
        SRC_LOAD:  ptr_q <= ADDR_W'(din_q);
        SRC_START: ptr_q <= start_sel;
        SRC_INC:   ptr_q <= inc_val;
        default:   ptr_q <= ptr_q;
      endcase
    end
  end

  p_load_apply_r5: assert property (@(posedge clk) disable iff (rst)
    ld_pend |=> ptr_q == ADDR_W'($past(din_q)));
  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en_n && !ld_pend && start1_n && start2_n) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en_n && !ld_pend && start1_n && start2_n) |=> $stable(ptr_q));
  p_start1_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld_pend && !start1_n) |=> ptr_q == $past(start_val[0]));
endmodule

// File: rtl/eob_flag.sv
module eob_flag #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_fire,
  input  logic [ADDR_W-1:0] inc_val,
  input  logic [ADDR_W-1:0] end_val,
  input  logic              clr,
  output logic              flag_n
);
  logic hit;
  assign hit = inc_fire && (inc_val == end_val);

  always_ff @(posedge clk) begin
    if (rst)      flag_n <= 1'b1;
    else if (hit) flag_n <= 1'b0;
    else if (clr) flag_n <= 1'b1;
  end

  p_fall_on_count_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_n) |-> $past(inc_fire));
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (!flag_n && !clr) |=> !flag_n);
endmodule

// File: rtl/port_ctl.sv
module port_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic rw_n,
  input  logic oe_n,
  input  logic ld_n,
  input  logic start1_n,
  input  logic start2_n,
  input  logic ld_pend,
  output logic wr_stb,
  output logic rd_stb,
  output logic out_en,
  output logic proto_err
);
  logic rd_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb    <= 1'b0;
      rd_stb    <= 1'b0;
      rd_mode_q <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      wr_stb    <= !ce_n && !rw_n;
      rd_stb    <= !ce_n && rw_n && !oe_n;
      rd_mode_q <= !ce_n && rw_n;
      proto_err <= (!start1_n || !start2_n) && (!ld_n || ld_pend);
    end
  end

  assign out_en = rd_mode_q && !oe_n;

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, rd_stb}));
  p_write_r9: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !rw_n) |=> wr_stb);
  p_proto_r11: assert property (@(posedge clk) disable iff (rst)
    ((!start1_n || !start2_n) && !ld_n) |=> proto_err);
  p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !out_en);
endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen
  import seq_ptr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int LD_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en_n,
  input  logic              ld_n,
  input  logic              start1_n,
  input  logic              start2_n,
  input  logic              ce_n,
  input  logic              rw_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] sdata,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic              out_en,
  output logic              eob1_n,
  output logic              eob2_n,
  output logic              proto_err
);
  logic [N_BUF-1:0][ADDR_W-1:0] start_val;
  logic [N_BUF-1:0][ADDR_W-1:0] end_val;
  logic [N_BUF-1:0]             clr;
  logic [N_BUF-1:0]             flag_n;
  logic                         ld_pend;
  logic                         inc_fire;
  logic [ADDR_W-1:0]            inc_val;
  logic                         unused_hi_bits;

  assign unused_hi_bits = ^sdata[DATA_W-1:LD_W];

  cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .start_val(start_val), .end_val(end_val), .clr(clr)
  );

  ptr_core #(.ADDR_W(ADDR_W), .LD_W(LD_W)) u_ptr (
    .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .ld_n(ld_n),
    .start1_n(start1_n), .start2_n(start2_n), .ld_data(sdata[LD_W-1:0]),
    .start_val(start_val), .ptr_q(ptr), .ld_pend(ld_pend),
    .inc_fire(inc_fire), .inc_val(inc_val)
  );

  for (genvar i = 0; i < N_BUF; i++) begin : g_flag
    eob_flag #(.ADDR_W(ADDR_W)) u_flag (
      .clk(clk), .rst(rst), .inc_fire(inc_fire), .inc_val(inc_val),
      .end_val(end_val[i]), .clr(clr[i]), .flag_n(flag_n[i])
    );
  end

  assign eob1_n = flag_n[0];
  assign eob2_n = flag_n[1];

  port_ctl u_port (
    .clk(clk), .rst(rst), .ce_n(ce_n), .rw_n(rw_n), .oe_n(oe_n),
    .ld_n(ld_n), .start1_n(start1_n), .start2_n(start2_n), .ld_pend(ld_pend),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .out_en(out_en), .proto_err(proto_err)
  );
endmodule

// File: tb/tb_seq_addr_gen.sv
module tb_seq_addr_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en_n = 1'b1, ld_n = 1'b1, start1_n = 1'b1, start2_n = 1'b1;
  logic        ce_n = 1'b1, rw_n = 1'b1, oe_n = 1'b1;
  logic [15:0] sdata = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;
  logic [12:0] ptr;
  logic        wr_stb, rd_stb, out_en, eob1_n, eob2_n, proto_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  seq_addr_gen dut (
    .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .ld_n(ld_n),
    .start1_n(start1_n), .start2_n(start2_n), .ce_n(ce_n), .rw_n(rw_n),
    .oe_n(oe_n), .sdata(sdata), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ptr(ptr), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .out_en(out_en), .eob1_n(eob1_n), .eob2_n(eob2_n), .proto_err(proto_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input logic [2:0] a, input logic [12:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [12:0] e;
    oe_n = 1'b0;
    tick(); tick();
    // R1 reset state
    chk("R1 ptr", 32'(ptr), 0);
    chk("R1 eob1", 32'(eob1_n), 1);
    chk("R1 eob2", 32'(eob2_n), 1);
    chk("R1 wr", 32'(wr_stb), 0);
    chk("R1 rd", 32'(rd_stb), 0);
    chk("R1 proto", 32'(proto_err), 0);
    chk("R1 out_en", 32'(out_en), 0);
    rst = 1'b0; oe_n = 1'b1;

    // R2 hold with count disabled
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 hold", 32'(ptr), 0);
    end

    // R2/R7 full counting sweep with ce_n toggling; end regs are 0
    cnt_en_n = 1'b0;
    for (int i = 1; i <= 8192; i++) begin
      ce_n = i[0];
      tick();
      chk("R2 count", 32'(ptr), 32'(i % 8192));
      chk("R7 eob1", 32'(eob1_n), (i == 8192) ? 0 : 1);
      chk("R7 eob2", 32'(eob2_n), (i == 8192) ? 0 : 1);
    end
    cnt_en_n = 1'b1; ce_n = 1'b1;

    // R6 ignored address, R8 partial clears
    cfg(3'd4, 13'd0);
    chk("R6 ignored eob1", 32'(eob1_n), 0);
    chk("R6 ignored eob2", 32'(eob2_n), 0);
    cfg(3'd5, 13'd2);
    chk("R8 clr1", 32'(eob1_n), 1);
    chk("R8 keep2", 32'(eob2_n), 0);
    cfg(3'd5, 13'd1);
    chk("R8 clr2", 32'(eob2_n), 1);
    chk("R8 keep1", 32'(eob1_n), 1);

    // R3/R5 load sweep: every 12-bit value, junk in upper bits, counting on
    e = ptr;
    cnt_en_n = 1'b0;
    for (int v = 0; v < 4096; v++) begin
      ld_n = 1'b0; sdata = {4'hF, 12'(v)};
      tick();
      e = e + 13'd1;
      chk("R3 capture edge", 32'(ptr), 32'(e));
      ld_n = 1'b1; sdata = 16'hFFFF;
      tick();
      e = 13'(v);
      chk("R5 load apply", 32'(ptr), 32'(e));
    end
    cnt_en_n = 1'b1;

    // R4/R6/R7 start registers
    cfg(3'd0, 13'd8190);
    cfg(3'd1, 13'd100);
    cfg(3'd2, 13'd8191);
    cfg(3'd3, 13'd101);
    start1_n = 1'b0; tick(); start1_n = 1'b1;
    chk("R4 start1", 32'(ptr), 8190);
    chk("R7 no set", 32'(eob1_n), 1);
    cnt_en_n = 1'b0; tick();
    chk("R2 inc", 32'(ptr), 8191);
    chk("R7 set1", 32'(eob1_n), 0);
    tick();
    chk("R2 wrap", 32'(ptr), 0);
    start2_n = 1'b0; tick(); start2_n = 1'b1;
    chk("R4 start2 over inc", 32'(ptr), 100);
    chk("R7 eob2 high", 32'(eob2_n), 1);
    tick();
    chk("R7 set2", 32'(eob2_n), 0);
    cnt_en_n = 1'b1;
    start1_n = 1'b0; start2_n = 1'b0; tick(); start1_n = 1'b1; start2_n = 1'b1;
    chk("R4 both start", 32'(ptr), 8190);
    cfg(3'd5, 13'd0);
    chk("R8 clear both", 32'({eob1_n, eob2_n}), 3);
    cfg(3'd0, 13'd8191);
    start1_n = 1'b0; tick(); start1_n = 1'b1;
    chk("R4 start end", 32'(ptr), 8191);
    chk("R7 jump no set", 32'(eob1_n), 1);
    cfg(3'd0, 13'd8190);
    start1_n = 1'b0; tick(); start1_n = 1'b1;
    cnt_en_n = 1'b0;
    cfg(3'd5, 13'd0);
    cnt_en_n = 1'b1;
    chk("R8 set wins", 32'(eob1_n), 0);
    chk("R8 set ptr", 32'(ptr), 8191);

    // R11/R5 load vs start conflict
    ld_n = 1'b0; sdata = 16'd77; start1_n = 1'b0;
    tick();
    ld_n = 1'b1; start1_n = 1'b1; start2_n = 1'b0;
    chk("R11 err on load edge", 32'(proto_err), 1);
    chk("R4 start at capture", 32'(ptr), 8190);
    tick();
    start2_n = 1'b1;
    chk("R11 err on pending", 32'(proto_err), 1);
    chk("R5 load beats start", 32'(ptr), 77);
    tick();
    chk("R11 clean", 32'(proto_err), 0);
    chk("R5 hold", 32'(ptr), 77);

    // R9/R10 strobe and output-enable combinations
    for (int c = 0; c < 8; c++) begin
      logic ce, rw, oe;
      ce = c[2]; rw = c[1]; oe = c[0];
      ce_n = ce; rw_n = rw; oe_n = oe;
      tick();
      chk("R9 wr", 32'(wr_stb), 32'(!ce && !rw));
      chk("R9 rd", 32'(rd_stb), 32'(!ce && rw && !oe));
      for (int o = 0; o < 2; o++) begin
        oe_n = o[0];
        #1;
        chk("R10 out_en", 32'(out_en), 32'(!ce && rw && !o[0]));
      end
    end
    ce_n = 1'b1; rw_n = 1'b1; oe_n = 1'b1;

    // R1 reset mid-run clears start registers and flags
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 ptr again", 32'(ptr), 0);
    chk("R1 eob1 again", 32'(eob1_n), 1);
    start1_n = 1'b0; tick(); start1_n = 1'b1;
    chk("R1 start reg reset", 32'(ptr), 0);

    summary();
  end
endmodule